// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the bit clock and the frame clock of a serial audio port that runs as clock master. Both are divided down from the master clock that also runs the block. The frame length in master clocks is 512 times a ratio multiplier, halved once for each step of a sample-rate band. The number of bit clocks in a frame is the slot width times the slot count. The bit clock period is therefore the frame length divided by the bits per frame. A one-cycle frame-start strobe tells the data serializer where each frame begins.

The frame clock runs either as a square wave with 50% duty or as a pulse one bit clock long. It has a polarity control. The bit clock has an edge control that chooses whether data launches on its falling or its rising edge.

Configuration arrives as plain inputs. It is sampled only at frame boundaries, so a frame never mixes two settings. An enable input starts the clocks. When enable is dropped, the clocks finish the current frame and then go quiet. Reserved codes, or a slot geometry the master clock cannot produce, raise an error flag, and the clocks stay idle.

Top module: `audclk_gen`

## Requirements
- R1: `ratio_code` values 0, 1, 2, 3 and 4 select multipliers of 1, 2, 3, 4 and 6. Values 5 to 7 are reserved and count as an invalid configuration.
- R2: `rate_band` values 0 to 4 are valid, and values 5 to 7 are invalid. One frame lasts (512 × multiplier) / 2^band master-clock cycles, measured from one `frame_start` pulse to the next.
- R3: `slot_wide`=0 gives 16-bit slots and 1 gives 32-bit slots. `slot_count_sel` values 0, 1, 2 and 3 give 2, 4, 8 and 16 slots. A frame holds slot width × slot count bit periods, each P master clocks long, where P = frame length / bits per frame.
- R4: With `bclk_invert`=0, `bclk` is low for the first floor(P/2) cycles of each bit period and high for the rest, so each bit period starts on a falling edge. With `bclk_invert`=1, `bclk` is inverted while the clocks run.
- R5: In square mode (`lr_pulse`=0), `lrclk` is low for the first half of the frame's bit periods and high for the second half. `lr_invert`=1 inverts it while the clocks run.
- R6: In pulse mode (`lr_pulse`=1), `lrclk` is high only during bit period 0 of each frame, which is P master clocks.
- R7: `frame_start` is high for exactly one master-clock cycle, the first cycle of each frame.
- R8: `config_error` goes high one cycle after an invalid configuration is presented. A configuration is invalid if it uses a reserved code, if P is not an integer, or if P < 2. While the configuration is invalid, no frame starts and `bclk`, `lrclk` and `frame_start` stay low.
- R9: A configuration change made in the middle of a frame takes effect only at the next frame boundary. The current frame keeps its length.
- R10: When idle and `enable` is high with a valid configuration, `frame_start` appears one cycle later. When `enable` falls, the current frame runs to completion, and after it all outputs stay low.
- R11: While synchronous `rst` is high, and after it falls, all outputs are low until a frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Starts the clocks; when it falls, the current frame finishes and then the clocks stop |
| ratio_code | input | 3 | Master-clock multiplier select |
| rate_band | input | 3 | Sample-rate band select |
| slot_wide | input | 1 | 0: 16-bit slots, 1: 32-bit slots |
| slot_count_sel | input | 2 | Slot count select: 2, 4, 8 or 16 |
| lr_pulse | input | 1 | Frame clock as a one-bit pulse instead of a square wave |
| lr_invert | input | 1 | Inverts the frame clock |
| bclk_invert | input | 1 | Inverts the bit clock (data launches on the rising edge) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| frame_start | output | 1 | One-cycle strobe on the first cycle of a frame |
| config_error | output | 1 | Registered flag for an invalid configuration |

## Verification
The bench measures whole frames over five configurations, one for each multiplier. These include a 3-cycle bit period with an odd split and the smallest period of 2 cycles. A wrong multiplier table or band shift would show up as a wrong frame length, and a wrong half-period split would show up as a wrong count of bit-clock high cycles. The bench drops enable in the middle of a frame and changes the ratio in the middle of a frame. A design that stops or reloads at once would cut that frame short. The bench also presents reserved codes and a slot geometry that is too fast for the master clock. A design that misses either would start clocking or leave the error flag low.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int BASE_LOG2       = 9;   // 512 master clocks per frame at multiplier 1, band 0
    localparam int MAX_MULT        = 6;
    localparam int MAX_BAND        = 4;
    localparam int SLOT_LOG_NARROW = 4;   // 16-bit slot
    localparam int SLOT_LOG_WIDE   = 5;   // 32-bit slot
    localparam int CNT_LOG_MAX     = 4;   // up to 16 slots
    localparam int MIN_PERIOD      = 2;
    localparam int FRAME_W = $clog2((MAX_MULT << BASE_LOG2) + 1);
    localparam int BIT_W   = SLOT_LOG_WIDE + CNT_LOG_MAX + 1;

    typedef struct packed {
        logic [2:0] ratio;
        logic [2:0] band;
        logic       slot_wide;
        logic [1:0] slot_cnt;
        logic       lr_pulse;
        logic       lr_inv;
        logic       bclk_inv;
    } clk_cfg_t;

    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] period;
        logic [BIT_W-1:0]   nbits;
        logic               lr_pulse;
        logic               lr_inv;
        logic               bclk_inv;
    } run_cfg_t;

    function automatic int ratio_mult(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 4;
            3'd4:    return 6;
            default: return 0;
        endcase
    endfunction

    function automatic run_cfg_t decode_cfg(input clk_cfg_t c);
        run_cfg_t r;
        int mult;
        int lb;
        int fr;
        int per;
        mult = ratio_mult(c.ratio);
        lb   = (c.slot_wide ? SLOT_LOG_WIDE : SLOT_LOG_NARROW) + int'(c.slot_cnt) + 1;
        fr   = (int'(c.band) <= MAX_BAND) ? (mult << (BASE_LOG2 - int'(c.band))) : 0;
        per  = fr >> lb;
        r.valid    = (mult != 0) && (fr != 0) && ((per << lb) == fr) && (per >= MIN_PERIOD);
        r.period   = FRAME_W'(per);
        r.nbits    = BIT_W'(1 << lb);
        r.lr_pulse = c.lr_pulse;
        r.lr_inv   = c.lr_inv;
        r.bclk_inv = c.bclk_inv;
        return r;
    endfunction

endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
    import audclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  clk_cfg_t cfg_in,
    input  logic     frame_end,
    output logic     running,
    output run_cfg_t act,
    output logic     cfg_err
);

    run_cfg_t dec;

    always_comb dec = decode_cfg(cfg_in);

    // Settings are taken only while idle or on the last cycle of a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            act     <= '0;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !dec.valid;
            if (!running || frame_end) begin
                if (enable && dec.valid) begin
                    running <= 1'b1;
                    act     <= dec;
                end else begin
                    running <= 1'b0;
                end
            end
        end
    end

    AST_CFG_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_end) |=> $stable(act)); // R9
    AST_RUN_UNTIL_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (running && !frame_end) |=> running); // R10
    AST_BAD_CFG_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!running && !dec.valid) |=> !running); // R8
    AST_ACTIVE_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
        running |-> act.valid); // R8

endmodule

// File: rtl/audclk_counters.sv
module audclk_counters #(
    parameter int PER_W = audclk_pkg::FRAME_W,
    parameter int CNT_W = audclk_pkg::BIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] nbits,
    output logic [PER_W-1:0] mc,
    output logic [CNT_W-1:0] bitn,
    output logic             frame_end
);

    logic bit_last_cycle;

    always_comb begin
        bit_last_cycle = (mc == period - 1'b1);
        frame_end      = running && bit_last_cycle && (bitn == nbits - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || !running || frame_end) begin
            mc   <= '0;
            bitn <= '0;
        end else if (bit_last_cycle) begin
            mc   <= '0;
            bitn <= bitn + 1'b1;
        end else begin
            mc   <= mc + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (mc < period && bitn < nbits)); // R3

endmodule

// File: rtl/audclk_outgen.sv
module audclk_outgen #(
    parameter int PER_W = audclk_pkg::FRAME_W,
    parameter int CNT_W = audclk_pkg::BIT_W
) (
    input  logic             running,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] nbits,
    input  logic             lr_pulse,
    input  logic             lr_inv,
    input  logic             bclk_inv,
    input  logic [PER_W-1:0] mc,
    input  logic [CNT_W-1:0] bitn,
    output logic             bclk,
    output logic             lrclk,
    output logic             frame_start
);

    logic bclk_raw;
    logic lr_raw;

    always_comb begin
        bclk_raw    = (mc >= (period >> 1));
        lr_raw      = lr_pulse ? (bitn == '0) : (bitn >= (nbits >> 1));
        bclk        = running && (bclk_raw ^ bclk_inv);
        lrclk       = running && (lr_raw ^ lr_inv);
        frame_start = running && (mc == '0) && (bitn == '0);
    end

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
    import audclk_pkg::*;
#(
    parameter int PER_W = FRAME_W,
    parameter int CNT_W = BIT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic [2:0] ratio_code,
    input  logic [2:0] rate_band,
    input  logic       slot_wide,
    input  logic [1:0] slot_count_sel,
    input  logic       lr_pulse,
    input  logic       lr_invert,
    input  logic       bclk_invert,
    output logic       bclk,
    output logic       lrclk,
    output logic       frame_start,
    output logic       config_error
);

    clk_cfg_t         cfg_in;
    run_cfg_t         act;
    logic             running;
    logic             frame_end;
    logic [PER_W-1:0] mc;
    logic [CNT_W-1:0] bitn;

    always_comb begin
        cfg_in.ratio     = ratio_code;
        cfg_in.band      = rate_band;
        cfg_in.slot_wide = slot_wide;
        cfg_in.slot_cnt  = slot_count_sel;
        cfg_in.lr_pulse  = lr_pulse;
        cfg_in.lr_inv    = lr_invert;
        cfg_in.bclk_inv  = bclk_invert;
    end

    audclk_ctrl ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cfg_in    (cfg_in),
        .frame_end (frame_end),
        .running   (running),
        .act       (act),
        .cfg_err   (config_error)
    );

    audclk_counters #(.PER_W(PER_W), .CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .running   (running),
        .period    (PER_W'(act.period)),
        .nbits     (CNT_W'(act.nbits)),
        .mc        (mc),
        .bitn      (bitn),
        .frame_end (frame_end)
    );

    audclk_outgen #(.PER_W(PER_W), .CNT_W(CNT_W)) out_i (
        .running     (running),
        .period      (PER_W'(act.period)),
        .nbits       (CNT_W'(act.nbits)),
        .lr_pulse    (act.lr_pulse),
        .lr_inv      (act.lr_inv),
        .bclk_inv    (act.bclk_inv),
        .mc          (mc),
        .bitn        (bitn),
        .bclk        (bclk),
        .lrclk       (lrclk),
        .frame_start (frame_start)
    );

    AST_FS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!bclk && !lrclk && !frame_start)); // R10

endmodule

// File: tb/audclk_gen_tb_top.sv
module audclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [2:0] ratio_code = 3'd0;
    logic [2:0] rate_band = 3'd0;
    logic       slot_wide = 1'b0;
    logic [1:0] slot_count_sel = 2'd0;
    logic       lr_pulse = 1'b0;
    logic       lr_invert = 1'b0;
    logic       bclk_invert = 1'b0;
    logic       bclk, lrclk, frame_start, config_error;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    audclk_gen dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .ratio_code(ratio_code), .rate_band(rate_band),
        .slot_wide(slot_wide), .slot_count_sel(slot_count_sel),
        .lr_pulse(lr_pulse), .lr_invert(lr_invert), .bclk_invert(bclk_invert),
        .bclk(bclk), .lrclk(lrclk), .frame_start(frame_start),
        .config_error(config_error)
    );

    typedef struct packed {
        logic [2:0] ratio;
        logic [2:0] band;
        logic       wide;
        logic [1:0] cnt;
        logic       pulse;
        int         len;
        int         bhi;
        int         lhi;
    } vec_t;

    // len: frame length, bhi: bclk high cycles, lhi: lrclk high cycles per frame
    localparam vec_t VECS [5] = '{
        '{3'd0, 3'd0, 1'b0, 2'd0, 1'b0,  512, 256, 256},  // x1, P=16, 32 bits
        '{3'd2, 3'd2, 1'b1, 2'd1, 1'b0,  384, 256, 192},  // x3, P=3, 128 bits
        '{3'd4, 3'd1, 1'b0, 2'd2, 1'b1, 1536, 768,  12},  // x6, P=12, pulse
        '{3'd3, 3'd4, 1'b1, 2'd0, 1'b0,  128,  64,  64},  // x4, P=2, 64 bits
        '{3'd1, 3'd0, 1'b1, 2'd3, 1'b1, 1024, 512,   2}   // x2, P=2, 512 bits, pulse
    };

    task automatic summary();
        $display("test done: total=%0d bad=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] r, input logic [2:0] b, input logic w,
                           input logic [1:0] c, input logic p, input logic li, input logic bi);
        ratio_code = r; rate_band = b; slot_wide = w; slot_count_sel = c;
        lr_pulse = p; lr_invert = li; bclk_invert = bi;
    endtask

    // Called at a negedge where frame_start is seen; returns at the next one.
    task automatic measure_frame(output int len, output int bhi, output int lhi);
        len = 0; bhi = 0; lhi = 0;
        do begin
            bhi += int'(bclk);
            lhi += int'(lrclk);
            len++;
            @(negedge clk);
        end while (!frame_start && len < 5000);
    endtask

    task automatic stop_and_idle(input int cycles);
        enable = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        int len, bhi, lhi, cnt_fs, cnt_b;

        // R11: reset
        repeat (4) @(negedge clk);
        chk("R11 bclk in reset", int'(bclk), 0);
        chk("R11 lrclk in reset", int'(lrclk), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 frame_start after reset", int'(frame_start), 0);
        chk("R11 config_error after reset", int'(config_error), 0);
        chk("R11 bclk after reset", int'(bclk), 0);

        // Vector table: R1 R2 R3 R4 R5 R6 R10
        foreach (VECS[i]) begin
            set_cfg(VECS[i].ratio, VECS[i].band, VECS[i].wide, VECS[i].cnt, VECS[i].pulse, 1'b0, 1'b0);
            enable = 1'b1;
            @(negedge clk);
            chk($sformatf("R10 start latency vec%0d", i), int'(frame_start), 1);
            measure_frame(len, bhi, lhi);
            chk($sformatf("R2 R1 frame length vec%0d", i), len, VECS[i].len);
            chk($sformatf("R3 R4 bclk high cycles vec%0d", i), bhi, VECS[i].bhi);
            chk($sformatf("%s lrclk high cycles vec%0d", VECS[i].pulse ? "R6" : "R5", i), lhi, VECS[i].lhi);
            measure_frame(len, bhi, lhi);
            chk($sformatf("R7 second frame length vec%0d", i), len, VECS[i].len);
            stop_and_idle(3200);
            chk($sformatf("R10 idle bclk vec%0d", i), int'(bclk), 0);
            chk($sformatf("R10 idle lrclk vec%0d", i), int'(lrclk), 0);
        end

        // R4 R5: inversion at the frame origin and mid-bit
        set_cfg(3'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1);
        enable = 1'b1;
        @(negedge clk);
        chk("R7 frame_start inverted run", int'(frame_start), 1);
        chk("R4 inverted bclk at offset 0", int'(bclk), 1);
        chk("R5 inverted lrclk at offset 0", int'(lrclk), 1);
        repeat (8) @(negedge clk);
        chk("R4 inverted bclk at offset 8", int'(bclk), 0);
        stop_and_idle(600);

        // R10: stop in the middle of a frame
        set_cfg(3'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        chk("R4 bclk at offset 0", int'(bclk), 0);
        chk("R5 lrclk at offset 0", int'(lrclk), 0);
        repeat (100) @(negedge clk);
        enable = 1'b0;
        repeat (411) @(negedge clk);
        chk("R10 bclk still running at offset 511", int'(bclk), 1);
        chk("R10 lrclk still running at offset 511", int'(lrclk), 1);
        @(negedge clk);
        chk("R10 bclk low after frame end", int'(bclk), 0);
        chk("R10 lrclk low after frame end", int'(lrclk), 0);
        cnt_fs = 0;
        repeat (600) begin
            @(negedge clk);
            cnt_fs += int'(frame_start);
        end
        chk("R10 no frame after stop", cnt_fs, 0);

        // R9: ratio change in the middle of a frame
        enable = 1'b1;
        @(negedge clk);
        repeat (10) @(negedge clk);
        ratio_code = 3'd1;
        len = 10;
        do begin
            @(negedge clk);
            len++;
        end while (!frame_start && len < 5000);
        chk("R9 current frame keeps length", len, 512);
        measure_frame(len, bhi, lhi);
        chk("R9 new length at next frame", len, 1024);
        stop_and_idle(1100);

        // R8: reserved and infeasible configurations
        set_cfg(3'd5, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        chk("R8 R1 reserved ratio flagged", int'(config_error), 1);
        cnt_fs = 0; cnt_b = 0;
        repeat (600) begin
            @(negedge clk);
            cnt_fs += int'(frame_start);
            cnt_b  += int'(bclk) + int'(lrclk);
        end
        chk("R8 no frame on reserved ratio", cnt_fs, 0);
        chk("R8 clocks low on reserved ratio", cnt_b, 0);
        set_cfg(3'd0, 3'd6, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 R2 reserved band flagged", int'(config_error), 1);
        chk("R8 no frame on reserved band", int'(frame_start), 0);
        set_cfg(3'd1, 3'd3, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 geometry too fast flagged", int'(config_error), 1);
        repeat (20) @(negedge clk);
        chk("R8 no bclk on bad geometry", int'(bclk), 0);
        set_cfg(3'd0, 3'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 flag clears on valid cfg", int'(config_error), 0);
        chk("R10 starts with valid cfg", int'(frame_start), 1);
        stop_and_idle(600);

        summary();
        $finish;
    end

endmodule